// File: doc/BRIEF.md
# Multichannel Block Word Transfer Controller

This block moves blocks of words between a single-ported memory and up to sixteen input peripherals and sixteen output peripherals, without help from the processor once a transfer has been set up. Each channel owns a transfer descriptor made of an address-step mode, a remaining word count and a current memory address. Software writes a descriptor through the program port. From then on, every request from that channel's peripheral moves one word. An input channel's word is written to memory. An output channel's word is read from memory and handed to the peripheral. After each word the channel's address steps and its count drops by one.

A channel is active while its count is nonzero. When several active channels request at once, the lowest slot wins, and input channels rank above output channels. The block serves one word at a time. A request that loses arbitration simply stays pending. When the count of a monitored channel reaches zero, that channel's end-of-transfer interrupt line pulses for one cycle. An output channel can be marked to carry control words for its device instead of data. Those words leave with a separate function strobe raised beside the acknowledge.

Top module: `io_xfer_ctrl`

## Requirements
- R1: A load on the program port with progWe=1 writes the descriptor of slot {progDir, progCh}, where progDir=0 selects an input channel and progDir=1 an output channel. The first word moved after a load uses the loaded address exactly.
- R2: One cycle after an active input channel is granted, the block holds memReq=1 and memWe=1 for one cycle, with memAddr equal to the channel's current address and memWdata equal to that channel's inData lane. The channel's inAck bit is high in the same cycle.
- R3: One cycle after an active output channel is granted, the block issues a read (memReq=1, memWe=0) for one cycle. In the next cycle it raises the channel's outAck bit with outData equal to memRdata. outData is zero whenever no outAck bit is high.
- R4: After each word, mode 2'b00 adds one to the address and mode 2'b10 subtracts one, both modulo 2^18. Modes 2'b01 and 2'b11 leave the address unchanged.
- R5: Each word decrements the count. A channel whose count is zero is inactive: its requests get no acknowledge and cause no memory access.
- R6: If progMon was 1 at load, the channel's interrupt bit (irqIn or irqOut) is high for exactly one cycle, in the cycle after the acknowledge of the last word. If progMon was 0, the bit stays low.
- R7: Loading a count of zero ends the channel at once with no memory access. If progMon=1 the interrupt bit pulses for one cycle in the cycle after the load.
- R8: Among active requesting channels, the lowest slot is granted first. Every input channel ranks above every output channel.
- R9: At most one acknowledge bit is high in any cycle. A losing request stays pending and is served later without being raised again.
- R10: outFunc is high together with outAck for an output channel loaded with progFunc=1. It is low at all other times.
- R11: Reloading an active channel replaces its descriptor. Later words use the new address and the new count, and nothing is left of the old count.
- R12: After reset all channels are inactive, and no acknowledge, memory request or interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progWe | input | 1 | Descriptor write strobe |
| progDir | input | 1 | 0 = input channel, 1 = output channel |
| progCh | input | 4 | Channel number within the direction |
| progMode | input | 2 | Address-step mode |
| progCount | input | 16 | Words to transfer |
| progAddr | input | 18 | Starting memory address |
| progMon | input | 1 | Raise end-of-transfer interrupt |
| progFunc | input | 1 | Output channel carries function words |
| inReq | input | 16 | Input channel requests |
| inData | input | 576 | Input channel data lanes, 36 bits per channel, channel 0 lowest |
| inAck | output | 16 | Input word accepted |
| outReq | input | 16 | Output channel requests |
| outAck | output | 16 | Output word valid on outData |
| outData | output | 36 | Output word |
| outFunc | output | 1 | Output word is a function word |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 18 | Memory address |
| memWdata | output | 36 | Memory write data |
| memRdata | input | 36 | Memory read data, one cycle after a read |
| irqIn | output | 16 | Input channel end-of-transfer pulses |
| irqOut | output | 16 | Output channel end-of-transfer pulses |

## Verification
The transfer path is exercised with six descriptors that cover both directions and all four step modes. Among them are an incrementing run that crosses the top of the 18-bit address space, a decrementing run, and held-address runs in each direction. Every word's address and data are compared, so a wrong step sign, a missing wrap or a stale first address each show up at a distinct word index. Simultaneous requests from two inputs and one output separate slot order from direction order. A zero-count load, requests on drained channels and a mid-transfer reload show whether the count logic or the descriptor replacement is at fault.

// File: rtl/io_xfer_pkg.sv
package io_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITE   = 2'd1,
    ST_READ    = 2'd2,
    ST_DELIVER = 2'd3
  } seqState_t;

  // strobes from sequencer to descriptor table / port logic
  typedef struct packed {
    logic upd;     // advance selected descriptor
    logic memRd;   // read cycle for an output channel
    logic memWr;   // write cycle for an input channel
    logic ackIn;   // acknowledge selected input channel
    logic ackOut;  // acknowledge selected output channel
  } seqStrobe_t;

  localparam logic [1:0] MODE_UP   = 2'b00;
  localparam logic [1:0] MODE_DOWN = 2'b10;

endpackage

// File: rtl/io_xfer_table.sv
module io_xfer_table
  import io_xfer_pkg::*;
#(
  parameter int NUM_SLOT = 32,
  parameter int SLOT_W   = 5,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                progWe,
  input  logic [SLOT_W-1:0]   progSlot,
  input  logic [1:0]          progMode,
  input  logic [CNT_W-1:0]    progCount,
  input  logic [ADDR_W-1:0]   progAddr,
  input  logic                progMon,
  input  logic                progFunc,
  input  seqStrobe_t          strobe,
  input  logic [SLOT_W-1:0]   selSlot,
  output logic [NUM_SLOT-1:0] activeVec,
  output logic [ADDR_W-1:0]   selAddr,
  output logic                selFunc,
  output logic [NUM_SLOT-1:0] irqVec
);

  logic [NUM_SLOT-1:0][ADDR_W-1:0] addrFlat;
  logic [NUM_SLOT-1:0]             funcVec;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic [CNT_W-1:0]  cntQ;
    logic [ADDR_W-1:0] addrQ;
    logic [1:0]        modeQ;
    logic              monQ;
    logic              funcQ;
    logic              loadHit;
    logic              updHit;

    assign loadHit = progWe && (progSlot == SLOT_W'(s));
    assign updHit  = strobe.upd && (selSlot == SLOT_W'(s)) && (cntQ != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ     <= '0;
        addrQ    <= '0;
        modeQ    <= MODE_UP;
        monQ     <= 1'b0;
        funcQ    <= 1'b0;
        irqVec[s] <= 1'b0;
      end else if (loadHit) begin
        cntQ     <= progCount;
        addrQ    <= progAddr;
        modeQ    <= progMode;
        monQ     <= progMon;
        funcQ    <= progFunc;
        irqVec[s] <= progMon && (progCount == '0);
      end else begin
        irqVec[s] <= updHit && monQ && (cntQ == CNT_W'(1));
        if (updHit) begin
          cntQ <= cntQ - CNT_W'(1);
          case (modeQ)
            MODE_UP:   addrQ <= addrQ + ADDR_W'(1);
            MODE_DOWN: addrQ <= addrQ - ADDR_W'(1);
            default:   addrQ <= addrQ;
          endcase
        end
      end
    end

    assign activeVec[s] = (cntQ != '0);
    assign addrFlat[s]  = addrQ;
    assign funcVec[s]   = funcQ;
  end

  assign selAddr = addrFlat[selSlot];
  assign selFunc = funcVec[selSlot];

endmodule

// File: rtl/io_xfer_sequencer.sv
module io_xfer_sequencer
  import io_xfer_pkg::*;
#(
  parameter int NUM_SLOT = 32,
  parameter int SLOT_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SLOT-1:0] reqVec,
  input  logic [NUM_SLOT-1:0] activeVec,
  input  logic                progWe,
  input  logic [SLOT_W-1:0]   progSlot,
  output seqStrobe_t          strobe,
  output logic [SLOT_W-1:0]   selSlot
);

  seqState_t           stateQ;
  logic [NUM_SLOT-1:0] loadMask;
  logic [NUM_SLOT-1:0] eligible;
  logic                grantValid;
  logic [SLOT_W-1:0]   grantSlot;

  assign loadMask = progWe ? (NUM_SLOT'(1) << progSlot) : '0;
  assign eligible = reqVec & activeVec & ~loadMask;

  // lowest slot wins: scan downward so the last hit is the lowest
  always_comb begin
    grantValid = 1'b0;
    grantSlot  = '0;
    for (int s = NUM_SLOT - 1; s >= 0; s--) begin
      if (eligible[s]) begin
        grantValid = 1'b1;
        grantSlot  = SLOT_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      selSlot <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (grantValid) begin
            selSlot <= grantSlot;
            stateQ  <= grantSlot[SLOT_W-1] ? ST_READ : ST_WRITE;
          end
        end
        ST_READ: begin
          // a reload of the channel being served drops the pending delivery
          if (progWe && (progSlot == selSlot)) stateQ <= ST_IDLE;
          else                                 stateQ <= ST_DELIVER;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.memWr  = (stateQ == ST_WRITE);
    strobe.ackIn  = (stateQ == ST_WRITE);
    strobe.memRd  = (stateQ == ST_READ);
    strobe.ackOut = (stateQ == ST_DELIVER);
    strobe.upd    = (stateQ == ST_WRITE) || (stateQ == ST_DELIVER);
  end

endmodule

// File: rtl/io_xfer_ctrl.sv
module io_xfer_ctrl
  import io_xfer_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 36,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     progWe,
  input  logic                     progDir,
  input  logic [$clog2(NUM_CH)-1:0] progCh,
  input  logic [1:0]               progMode,
  input  logic [CNT_W-1:0]         progCount,
  input  logic [ADDR_W-1:0]        progAddr,
  input  logic                     progMon,
  input  logic                     progFunc,
  input  logic [NUM_CH-1:0]        inReq,
  input  logic [NUM_CH*DATA_W-1:0] inData,
  output logic [NUM_CH-1:0]        inAck,
  input  logic [NUM_CH-1:0]        outReq,
  output logic [NUM_CH-1:0]        outAck,
  output logic [DATA_W-1:0]        outData,
  output logic                     outFunc,
  output logic                     memReq,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [NUM_CH-1:0]        irqIn,
  output logic [NUM_CH-1:0]        irqOut
);

  localparam int CH_W     = $clog2(NUM_CH);
  localparam int NUM_SLOT = 2 * NUM_CH;
  localparam int SLOT_W   = CH_W + 1;

  seqStrobe_t          strobe;
  logic [SLOT_W-1:0]   selSlot;
  logic [SLOT_W-1:0]   progSlot;
  logic [NUM_SLOT-1:0] activeVec;
  logic [NUM_SLOT-1:0] irqVec;
  logic [ADDR_W-1:0]   selAddr;
  logic                selFunc;
  logic [CH_W-1:0]     selCh;
  logic [NUM_CH-1:0]   chOneHot;

  assign progSlot = {progDir, progCh};
  assign selCh    = selSlot[CH_W-1:0];
  assign chOneHot = NUM_CH'(1) << selCh;

  io_xfer_sequencer #(
    .NUM_SLOT (NUM_SLOT),
    .SLOT_W   (SLOT_W)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    ({outReq, inReq}),
    .activeVec (activeVec),
    .progWe    (progWe),
    .progSlot  (progSlot),
    .strobe    (strobe),
    .selSlot   (selSlot)
  );

  io_xfer_table #(
    .NUM_SLOT (NUM_SLOT),
    .SLOT_W   (SLOT_W),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) u_table (
    .clk       (clk),
    .rstN      (rstN),
    .progWe    (progWe),
    .progSlot  (progSlot),
    .progMode  (progMode),
    .progCount (progCount),
    .progAddr  (progAddr),
    .progMon   (progMon),
    .progFunc  (progFunc),
    .strobe    (strobe),
    .selSlot   (selSlot),
    .activeVec (activeVec),
    .selAddr   (selAddr),
    .selFunc   (selFunc),
    .irqVec    (irqVec)
  );

  assign memReq   = strobe.memRd || strobe.memWr;
  assign memWe    = strobe.memWr;
  assign memAddr  = selAddr;
  assign memWdata = inData[selCh*DATA_W +: DATA_W];

  assign inAck    = strobe.ackIn  ? chOneHot : '0;
  assign outAck   = strobe.ackOut ? chOneHot : '0;
  assign outData  = strobe.ackOut ? memRdata : '0;
  assign outFunc  = strobe.ackOut && selFunc;

  assign irqIn    = irqVec[NUM_CH-1:0];
  assign irqOut   = irqVec[NUM_SLOT-1:NUM_CH];

endmodule

// File: rtl/io_xfer_ctrl_chk.sv
module io_xfer_ctrl_chk #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] inAck,
  input logic [NUM_CH-1:0] outAck,
  input logic [DATA_W-1:0] outData,
  input logic              outFunc,
  input logic              memReq,
  input logic              memWe
);

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outAck, inAck})); // R9

  AST_IN_ACK_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (|inAck) |-> (memReq && memWe)); // R2

  AST_OUT_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (|outAck) |-> $past(memReq && !memWe)); // R3

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(|outAck) |-> (outData == '0)); // R3

  AST_FUNC_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    outFunc |-> (|outAck)); // R10

endmodule

bind io_xfer_ctrl io_xfer_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inAck   (inAck),
  .outAck  (outAck),
  .outData (outData),
  .outFunc (outFunc),
  .memReq  (memReq),
  .memWe   (memWe)
);

// File: tb/tb_io_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_io_xfer_ctrl;
  localparam int NUM_CH = 16;
  localparam int DATA_W = 36;
  localparam int ADDR_W = 18;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic        dir;
    logic [3:0]  ch;
    logic [1:0]  mode;
    logic [15:0] cnt;
    logic [17:0] addr;
    logic        mon;
    logic        func;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd0,  2'b00, 16'd3, 18'd10,      1'b1, 1'b0},
    '{1'b0, 4'd5,  2'b10, 16'd3, 18'd40,      1'b0, 1'b0},
    '{1'b1, 4'd2,  2'b01, 16'd2, 18'd60,      1'b1, 1'b0},
    '{1'b1, 4'd15, 2'b11, 16'd2, 18'd70,      1'b0, 1'b1},
    '{1'b1, 4'd7,  2'b00, 16'd4, 18'h3FFFE,   1'b1, 1'b1},
    '{1'b0, 4'd9,  2'b11, 16'd3, 18'd90,      1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progWe = 1'b0, progDir = 1'b0, progMon = 1'b0, progFunc = 1'b0;
  logic [3:0] progCh = '0;
  logic [1:0] progMode = '0;
  logic [CNT_W-1:0] progCount = '0;
  logic [ADDR_W-1:0] progAddr = '0;
  logic [NUM_CH-1:0] inReq = '0, outReq = '0;
  logic [NUM_CH*DATA_W-1:0] inData;
  logic [NUM_CH-1:0] inAck, outAck, irqIn, irqOut;
  logic [DATA_W-1:0] outData, memWdata;
  logic [DATA_W-1:0] memRdata = '0;
  logic outFunc, memReq, memWe;
  logic [ADDR_W-1:0] memAddr;

  always #2.5 clk = ~clk;

  io_xfer_ctrl dut (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progDir(progDir), .progCh(progCh),
    .progMode(progMode), .progCount(progCount), .progAddr(progAddr),
    .progMon(progMon), .progFunc(progFunc), .inReq(inReq), .inData(inData),
    .inAck(inAck), .outReq(outReq), .outAck(outAck), .outData(outData),
    .outFunc(outFunc), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  function automatic logic [DATA_W-1:0] memInit(input logic [7:0] a);
    return {12'hA5C, a, ~a, 8'h3C};
  endfunction

  function automatic logic [DATA_W-1:0] inWord(input int ch, input logic [15:0] sq);
    return {4'(ch), 16'hBEEF, sq};
  endfunction

  // memory model: write in the request cycle, read data one cycle later
  logic [DATA_W-1:0] mem [256];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= memInit(8'(i));
    end else begin
      if (memReq && memWe)  mem[memAddr[7:0]] <= memWdata;
      if (memReq && !memWe) memRdata <= mem[memAddr[7:0]];
    end
  end

  // peripheral data lanes: each input channel advances its sequence per ack
  logic [15:0] inSeq [NUM_CH];
  always @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (!rstN) inSeq[c] <= '0;
      else if (inAck[c]) inSeq[c] <= inSeq[c] + 16'd1;
    end
  end
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) inData[c*DATA_W +: DATA_W] = inWord(c, inSeq[c]);
  end

  // interrupt cycle counters and acknowledge order log
  int irqCnt [2*NUM_CH];
  int ackLog [64];
  int ackNum = 0;
  initial for (int i = 0; i < 2*NUM_CH; i++) irqCnt[i] = 0;
  always @(negedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (irqIn[i])  irqCnt[i]++;
      if (irqOut[i]) irqCnt[NUM_CH+i]++;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (inAck[i])  begin ackLog[ackNum % 64] = i;          ackNum++; end
      if (outAck[i]) begin ackLog[ackNum % 64] = NUM_CH + i; ackNum++; end
    end
  end

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic loadCh(input logic dir, input int ch, input logic [1:0] mode,
                        input logic [15:0] cnt, input logic [17:0] addr,
                        input logic mon, input logic func);
    @(negedge clk);
    progWe = 1'b1; progDir = dir; progCh = 4'(ch); progMode = mode;
    progCount = cnt; progAddr = addr; progMon = mon; progFunc = func;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  function automatic logic [17:0] expAddr(input logic [17:0] base, input logic [1:0] mode, input int k);
    if (mode == 2'b00) return base + 18'(k);
    if (mode == 2'b10) return base - 18'(k);
    return base;
  endfunction

  task automatic setReq(input logic dir, input int ch, input logic v);
    if (dir) outReq[ch] = v; else inReq[ch] = v;
  endtask

  task automatic runVector(input vec_t v);
    int slot, kReq, kAck, irq0, extra;
    logic [15:0] seq0;
    logic [17:0] a;
    slot = v.dir ? NUM_CH + int'(v.ch) : int'(v.ch);
    irq0 = irqCnt[slot];
    loadCh(v.dir, int'(v.ch), v.mode, v.cnt, v.addr, v.mon, v.func);
    seq0 = inSeq[v.ch];
    kReq = 0; kAck = 0;
    setReq(v.dir, int'(v.ch), 1'b1);
    for (int cyc = 0; cyc < 200 && kAck < int'(v.cnt); cyc++) begin
      @(negedge clk);
      if (memReq) begin
        a = expAddr(v.addr, v.mode, kReq);
        chk(memAddr == a, (kReq == 0) ? "R1" : "R4", "memAddr", 64'(memAddr), 64'(a));
        if (!v.dir) begin
          chk(memWe == 1'b1, "R2", "memWe", 64'(memWe), 64'd1);
          chk(memWdata == inWord(int'(v.ch), seq0 + 16'(kReq)), "R2", "memWdata",
              64'(memWdata), 64'(inWord(int'(v.ch), seq0 + 16'(kReq))));
        end else begin
          chk(memWe == 1'b0, "R3", "memWe", 64'(memWe), 64'd0);
        end
        kReq++;
      end
      if (!v.dir && inAck[v.ch]) kAck++;
      if (v.dir && outAck[v.ch]) begin
        a = expAddr(v.addr, v.mode, kAck);
        chk(outData == memInit(a[7:0]), "R3", "outData", 64'(outData), 64'(memInit(a[7:0])));
        chk(outFunc == v.func, "R10", "outFunc", 64'(outFunc), 64'(v.func));
        kAck++;
      end
    end
    chk(kAck == int'(v.cnt), "R5", "words acknowledged", 64'(kAck), 64'(v.cnt));
    // request kept high on the drained channel: nothing more may happen
    extra = 0;
    for (int cyc = 0; cyc < 10; cyc++) begin
      @(negedge clk);
      if (memReq || (|inAck) || (|outAck)) extra++;
    end
    chk(extra == 0, "R5", "activity after count reached zero", 64'(extra), 64'd0);
    chk(irqCnt[slot] - irq0 == (v.mon ? 1 : 0), "R6", "interrupt cycles",
        64'(irqCnt[slot] - irq0), 64'(v.mon ? 1 : 0));
    setReq(v.dir, int'(v.ch), 1'b0);
  endtask

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched + 1);
      $finish;
    end
  end

  initial begin
    int irq0, base, busy, acks;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(inAck == '0 && outAck == '0, "R12", "acks in reset", 64'({outAck, inAck}), 64'd0);
    chk(memReq == 1'b0, "R12", "memReq in reset", 64'(memReq), 64'd0);
    rstN = 1'b1;
    inReq[4] = 1'b1;
    busy = 0;
    for (int cyc = 0; cyc < 10; cyc++) begin
      @(negedge clk);
      if (memReq || (|inAck) || (|outAck) || (|irqIn) || (|irqOut)) busy++;
    end
    inReq[4] = 1'b0;
    chk(busy == 0, "R12", "activity on unloaded channel after reset", 64'(busy), 64'd0);

    // main table of transfers
    for (int i = 0; i < NVEC; i++) runVector(VECS[i]);

    // R7: zero count, monitored then unmonitored
    irq0 = irqCnt[3];
    busy = 0;
    loadCh(1'b0, 3, 2'b00, 16'd0, 18'd200, 1'b1, 1'b0);
    inReq[3] = 1'b1;
    for (int cyc = 0; cyc < 6; cyc++) begin
      @(negedge clk);
      if (memReq) busy++;
    end
    inReq[3] = 1'b0;
    chk(irqCnt[3] - irq0 == 1, "R7", "zero-count monitored interrupt", 64'(irqCnt[3] - irq0), 64'd1);
    chk(busy == 0, "R7", "memory access on zero count", 64'(busy), 64'd0);
    irq0 = irqCnt[NUM_CH+4];
    loadCh(1'b1, 4, 2'b00, 16'd0, 18'd200, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(irqCnt[NUM_CH+4] - irq0 == 0, "R7", "zero-count unmonitored interrupt",
        64'(irqCnt[NUM_CH+4] - irq0), 64'd0);

    // R8 / R9: simultaneous requests from output 0, input 3, input 1
    loadCh(1'b1, 0, 2'b00, 16'd1, 18'd150, 1'b0, 1'b0);
    loadCh(1'b0, 3, 2'b00, 16'd1, 18'd160, 1'b0, 1'b0);
    loadCh(1'b0, 1, 2'b00, 16'd1, 18'd170, 1'b0, 1'b0);
    base = ackNum;
    busy = 0;
    @(negedge clk);
    outReq[0] = 1'b1; inReq[3] = 1'b1; inReq[1] = 1'b1;
    for (int cyc = 0; cyc < 30; cyc++) begin
      @(negedge clk);
      if (memReq) busy++;
    end
    outReq[0] = 1'b0; inReq[3] = 1'b0; inReq[1] = 1'b0;
    chk(ackNum - base == 3, "R9", "pending requests all served", 64'(ackNum - base), 64'd3);
    chk(busy == 3, "R9", "one memory access per word", 64'(busy), 64'd3);
    chk(ackLog[base % 64] == 1, "R8", "first grant", 64'(ackLog[base % 64]), 64'd1);
    chk(ackLog[(base+1) % 64] == 3, "R8", "second grant", 64'(ackLog[(base+1) % 64]), 64'd3);
    chk(ackLog[(base+2) % 64] == NUM_CH, "R8", "input before output",
        64'(ackLog[(base+2) % 64]), 64'(NUM_CH));

    // R11: reload an active channel after one word
    loadCh(1'b0, 6, 2'b00, 16'd5, 18'd100, 1'b0, 1'b0);
    inReq[6] = 1'b1;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      if (inAck[6]) begin inReq[6] = 1'b0; break; end
    end
    loadCh(1'b0, 6, 2'b10, 16'd1, 18'd120, 1'b0, 1'b0);
    inReq[6] = 1'b1;
    busy = 0;
    acks = 0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      if (memReq) begin
        busy++;
        if (busy == 1) chk(memAddr == 18'd120, "R11", "address after reload", 64'(memAddr), 64'd120);
      end
      if (inAck[6]) acks++;
    end
    inReq[6] = 1'b0;
    chk(acks == 1, "R11", "words after reload", 64'(acks), 64'd1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule